// File: doc/BRIEF.md
# Multichannel Auxiliary ADC Sequencer

This block is the register-side controller of a sixteen-channel auxiliary converter. Software sets the power-enable bit and raises a channel's bit in the trigger register. The sequencer then queues that channel and issues a one-cycle start request to the converter, naming the channel. It waits for the converter's done strobe and files the 12-bit result in that channel's data word, where a sticky ready flag marks it as fresh. The status word shows busy from the trigger write until the last queued result is stored.

Lowering a trigger bit clears that channel's ready flag. Software can therefore follow a simple pattern: clear the bit, set it, then poll. When several bits rise in one write, the channels are converted one after another, lowest index first. A converter that never answers is abandoned after a parameterised number of ticks, and the ready flag of that channel stays low.

The core is a four-state machine. In `ST_IDLE` it waits for a queued channel (idle→launch). In `ST_LAUNCH` it drives the start pulse (launch→wait). In `ST_WAIT` it counts ticks until done (wait→store) or until the limit (wait→idle, abandoned). In `ST_STORE` it writes the result and the ready flag (store→idle).

Top module: `auxadc_sequencer`

## Requirements
- R1: After reset, every mapped register reads 0, status busy (bit 0 at 0x10) is 0 and the converter start output is low.
- R2: With power enabled, a write that takes a channel's bit in the trigger register (0x04, bit n = channel n) from 0 to 1 produces a start pulse naming that channel, and the trigger register reads back the written value.
- R3: Status bit 0 reads 1 from the cycle after an accepted trigger write until the last queued result is stored, and reads 0 once all stored results are visible.
- R4: The data word of channel c at 0x14 + 4·c holds the converter's result in bits 11:0 and a ready flag in bit 12, set when that result is stored; bits 31:13 read 0.
- R5: A write that takes a channel's trigger bit from 1 to 0 clears that channel's ready flag.
- R6: Channels whose bits rise in one write are converted one at a time, in ascending index order.
- R7: The power-enable bit is bit 14 at 0x94. While it is 0, writes to the trigger register are ignored: the register, the ready flags and the converter start output are unchanged.
- R8: If the converter gives no done within TIMEOUT_TICKS cycles of waiting, the conversion is abandoned: busy clears, and that channel's ready flag stays 0.
- R9: Writes to the status and data words have no effect, and reads of unmapped offsets (including 0x00) return 0.
- R10: The start output is high for exactly one cycle per conversion, and no new start is issued before the previous conversion ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 4 | Channel being converted |
| conv_done | input | 1 | Converter result strobe |
| conv_data | input | 12 | Converter result, valid with conv_done |

## Verification
An accepted trigger write is seen as busy in the same cycle as the write's clock edge. The start pulse follows one cycle after the write edge. A result arriving with done becomes readable, with ready set and busy clear, two edges later. The bench therefore reads the status word once per cycle right after each write and counts the cycles until busy falls. It compares the data words only after that, and it checks the timeout case against a window of TIMEOUT_TICKS plus the two launch cycles. The converter model records every start it sees at the falling edge, which checks the order and the one-cycle pulse width without any sampling race.

// File: rtl/auxadc_pkg.sv
package auxadc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_WAIT,
        ST_STORE
    } seq_state_t;

    localparam int OFS_TRIG  = 'h04;
    localparam int OFS_STAT  = 'h10;
    localparam int OFS_DATA0 = 'h14;
    localparam int OFS_PWR   = 'h94;
    localparam int PWR_BIT   = 14;

endpackage

// File: rtl/auxadc_trig_arbiter.sv
module auxadc_trig_arbiter #(
    parameter int NCH = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    trig_we,
    input  logic [NCH-1:0]          trig_wdata,
    input  logic                    pwr_on,
    input  logic                    take,
    output logic [NCH-1:0]          trig_q,
    output logic [NCH-1:0]          fall_mask,
    output logic                    pending_any,
    output logic [$clog2(NCH)-1:0]  pick_chan
);
    localparam int CW = $clog2(NCH);

    logic           accept;
    logic [NCH-1:0] rise_mask;
    logic [NCH-1:0] take_mask;
    logic [NCH-1:0] pending;

    assign accept    = trig_we & pwr_on;
    assign rise_mask = accept ? (trig_wdata & ~trig_q) : '0;
    assign fall_mask = accept ? (trig_q & ~trig_wdata) : '0;
    assign take_mask = take ? (NCH'(1) << pick_chan) : '0;
    assign pending_any = |pending;

    // lowest set index wins: scan downward so the last hit is the lowest
    always_comb begin
        pick_chan = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pending[i]) pick_chan = CW'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q  <= '0;
            pending <= '0;
        end else begin
            if (accept) trig_q <= trig_wdata;
            pending <= (pending & ~take_mask & ~fall_mask) | rise_mask;
        end
    end

    AST_TAKE_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (pending[pick_chan] &&
                  ((pending & ((NCH'(1) << pick_chan) - NCH'(1))) == '0))) // R6
        else $error("take not on lowest pending channel");

    AST_OFF_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_we && !pwr_on) |=> $stable(trig_q)) // R7
        else $error("trigger register changed while power off");

    AST_NO_QUEUE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> ((pending & ~$past(pending)) == '0)) // R7
        else $error("channel queued while power off");

endmodule

// File: rtl/auxadc_conv_fsm.sv
module auxadc_conv_fsm
    import auxadc_pkg::*;
#(
    parameter int NCH           = 16,
    parameter int RES_W         = 12,
    parameter int TIMEOUT_TICKS = 3125
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pending_any,
    input  logic [$clog2(NCH)-1:0]  pick_chan,
    input  logic                    conv_done,
    input  logic [RES_W-1:0]        conv_data,
    output logic                    take,
    output logic                    conv_start,
    output logic [$clog2(NCH)-1:0]  conv_chan,
    output logic                    fsm_busy,
    output logic                    wr_en,
    output logic [$clog2(NCH)-1:0]  wr_chan,
    output logic [RES_W-1:0]        wr_data
);
    localparam int CW    = $clog2(NCH);
    localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_TICKS - 1);

    seq_state_t        state, state_nx;
    logic [CNT_W-1:0]  wait_cnt;
    logic [CW-1:0]     chan_q;
    logic [RES_W-1:0]  data_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (pending_any) state_nx = ST_LAUNCH;
            ST_LAUNCH: state_nx = ST_WAIT;
            ST_WAIT: begin
                if (conv_done)                 state_nx = ST_STORE;
                else if (wait_cnt == CNT_LAST) state_nx = ST_IDLE;
            end
            ST_STORE:  state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            wait_cnt <= '0;
            chan_q   <= '0;
            data_q   <= '0;
        end else begin
            state <= state_nx;
            if (take) chan_q <= pick_chan;
            if (state == ST_LAUNCH)     wait_cnt <= '0;
            else if (state == ST_WAIT)  wait_cnt <= wait_cnt + 1'b1;
            if (state == ST_WAIT && conv_done) data_q <= conv_data;
        end
    end

    always_comb begin
        take       = (state == ST_IDLE) && pending_any;
        conv_start = (state == ST_LAUNCH);
        conv_chan  = chan_q;
        fsm_busy   = (state != ST_IDLE);
        wr_en      = (state == ST_STORE);
        wr_chan    = chan_q;
        wr_data    = data_q;
    end

    AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> (wait_cnt < CNT_W'(TIMEOUT_TICKS))) // R8
        else $error("wait counter passed limit");

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start) // R10
        else $error("start held longer than one cycle");

    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> ($past(state) == ST_IDLE)) // R10
        else $error("start not preceded by idle");

endmodule

// File: rtl/auxadc_result_bank.sv
module auxadc_result_bank #(
    parameter int NCH   = 16,
    parameter int RES_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [$clog2(NCH)-1:0]  wr_chan,
    input  logic [RES_W-1:0]        wr_data,
    input  logic [NCH-1:0]          clr_mask,
    input  logic [$clog2(NCH)-1:0]  rd_chan,
    output logic                    rd_ready,
    output logic [RES_W-1:0]        rd_result
);
    logic [NCH-1:0]   ready;
    logic [RES_W-1:0] result [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_chan == g);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ready[g]  <= 1'b0;
                result[g] <= '0;
            end else begin
                if (hit) result[g] <= wr_data;
                // software clear takes precedence over a same-cycle store
                if (clr_mask[g])  ready[g] <= 1'b0;
                else if (hit)     ready[g] <= 1'b1;
            end
        end
    end

    assign rd_ready  = ready[rd_chan];
    assign rd_result = result[rd_chan];

    AST_READY_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr_mask[wr_chan]) |=> ready[$past(wr_chan)]) // R4
        else $error("ready not set after store");

    AST_CLEAR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask != '0) |=> ((ready & $past(clr_mask)) == '0)) // R5
        else $error("ready survived a falling trigger");

endmodule

// File: rtl/auxadc_sequencer.sv
module auxadc_sequencer
    import auxadc_pkg::*;
#(
    parameter int NCH           = 16,
    parameter int RES_W         = 12,
    parameter int ADDR_W        = 8,
    parameter int TIMEOUT_TICKS = 3125
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_we,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    output logic                    conv_start,
    output logic [$clog2(NCH)-1:0]  conv_chan,
    input  logic                    conv_done,
    input  logic [RES_W-1:0]        conv_data
);
    localparam int CW = $clog2(NCH);
    localparam logic [ADDR_W-1:0] A_TRIG  = ADDR_W'(OFS_TRIG);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_DATA0 = ADDR_W'(OFS_DATA0);
    localparam logic [ADDR_W-1:0] A_DEND  = ADDR_W'(OFS_DATA0 + 4 * NCH);
    localparam logic [ADDR_W-1:0] A_PWR   = ADDR_W'(OFS_PWR);

    logic              pwr_on;
    logic              trig_we;
    logic [NCH-1:0]    trig_q, fall_mask;
    logic              pending_any, take, fsm_busy, busy;
    logic [CW-1:0]     pick_chan;
    logic              wr_en;
    logic [CW-1:0]     wr_chan, rd_chan;
    logic [RES_W-1:0]  wr_data, rd_result;
    logic              rd_ready;
    logic              in_data;
    logic [ADDR_W-1:0] data_ofs;
    logic              unused_bits;

    assign unused_bits = ^{bus_wdata[31:NCH], data_ofs[1:0]};

    assign trig_we  = bus_we && (bus_addr == A_TRIG);
    assign busy     = fsm_busy | pending_any;
    assign data_ofs = bus_addr - A_DATA0;
    assign rd_chan  = data_ofs[CW+1:2];
    assign in_data  = (bus_addr >= A_DATA0) && (bus_addr < A_DEND) &&
                      (bus_addr[1:0] == 2'b00);

    always_ff @(posedge clk) begin
        if (!rst_n)                              pwr_on <= 1'b0;
        else if (bus_we && bus_addr == A_PWR)    pwr_on <= bus_wdata[PWR_BIT];
    end

    auxadc_trig_arbiter #(.NCH(NCH)) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_we     (trig_we),
        .trig_wdata  (bus_wdata[NCH-1:0]),
        .pwr_on      (pwr_on),
        .take        (take),
        .trig_q      (trig_q),
        .fall_mask   (fall_mask),
        .pending_any (pending_any),
        .pick_chan   (pick_chan)
    );

    auxadc_conv_fsm #(
        .NCH           (NCH),
        .RES_W         (RES_W),
        .TIMEOUT_TICKS (TIMEOUT_TICKS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pending_any (pending_any),
        .pick_chan   (pick_chan),
        .conv_done   (conv_done),
        .conv_data   (conv_data),
        .take        (take),
        .conv_start  (conv_start),
        .conv_chan   (conv_chan),
        .fsm_busy    (fsm_busy),
        .wr_en       (wr_en),
        .wr_chan     (wr_chan),
        .wr_data     (wr_data)
    );

    auxadc_result_bank #(.NCH(NCH), .RES_W(RES_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_chan   (wr_chan),
        .wr_data   (wr_data),
        .clr_mask  (fall_mask),
        .rd_chan   (rd_chan),
        .rd_ready  (rd_ready),
        .rd_result (rd_result)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_TRIG)       bus_rdata[NCH-1:0] = trig_q;
        else if (bus_addr == A_STAT)  bus_rdata[0] = busy;
        else if (bus_addr == A_PWR)   bus_rdata[PWR_BIT] = pwr_on;
        else if (in_data)             bus_rdata[RES_W:0] = {rd_ready, rd_result};
    end

    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy) // R3
        else $error("start issued while status idle");

    AST_START_NEEDS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(pending_any)) // R2
        else $error("start without a queued channel");

endmodule

// File: tb/test_auxadc_sequencer.sv
module test_auxadc_sequencer;
    localparam int NCH = 16;
    localparam int TMO = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        conv_start;
    logic [3:0]  conv_chan;
    logic        conv_done = 1'b0;
    logic [11:0] conv_data = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [11:0] exp_val [NCH];
    int          chan_log [256];
    int          log_n = 0;
    bit          mute = 0;
    int          start_run = 0;

    always #4 clk = ~clk;

    auxadc_sequencer #(.TIMEOUT_TICKS(TMO)) i_auxadc_sequencer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_start(conv_start),
        .conv_chan(conv_chan), .conv_done(conv_done), .conv_data(conv_data)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] data_addr(input int ch);
        return 32'h14 + 32'(4 * ch);
    endfunction

    function automatic logic [31:0] exp_word(input int ch);
        return {19'b0, 1'b1, exp_val[ch]};
    endfunction

    // converter model: watches the start at falling edges
    initial begin
        forever begin
            @(negedge clk);
            if (conv_start === 1'b1) begin
                start_run++;
                if (start_run > 1) check(0, "R10 start width", 32'(start_run), 1);
                if (log_n < 256) chan_log[log_n] = int'(conv_chan);
                log_n++;
                if (!mute) begin
                    automatic int ch  = int'(conv_chan);
                    automatic int lat = int'($urandom_range(1, 8));
                    automatic logic [11:0] v = 12'($urandom);
                    repeat (lat) @(negedge clk);
                    start_run = 0;
                    exp_val[ch] = v;
                    conv_data = v;
                    conv_done = 1'b1;
                    @(negedge clk);
                    conv_done = 1'b0;
                end
            end else begin
                start_run = 0;
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        @(negedge clk);
    endtask

    task automatic wait_idle(input int limit, output int cycles);
        logic [31:0] s;
        cycles = 0;
        do begin
            bus_read(8'h10, s);
            cycles++;
        end while (s[0] && cycles < limit);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        finish_up();
    end

    initial begin
        logic [31:0] r;
        int cyc, base;
        for (int i = 0; i < NCH; i++) exp_val[i] = '0;
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(8'h04, r); check(r == 0, "R1 trig", r, 0);
        bus_read(8'h10, r); check(r == 0, "R1 status", r, 0);
        bus_read(8'h14, r); check(r == 0, "R1 data0", r, 0);
        bus_read(8'h50, r); check(r == 0, "R1 data15", r, 0);
        bus_read(8'h94, r); check(r == 0, "R1 power", r, 0);
        check(conv_start == 1'b0, "R1 start", 32'(conv_start), 0);

        // R7 trigger with power off
        bus_write(8'h04, 32'h0001);
        bus_read(8'h10, r); check(r == 0, "R7 busy off", r, 0);
        bus_read(8'h04, r); check(r == 0, "R7 trig off", r, 0);
        repeat (4) @(negedge clk);
        check(log_n == 0, "R7 no start", 32'(log_n), 0);

        bus_write(8'h94, 32'h4000);
        bus_read(8'h94, r); check(r == 32'h4000, "R7 power readback", r, 32'h4000);

        // R2 R3 R4 single channel
        bus_write(8'h04, 32'h0020);
        bus_read(8'h10, r); check(r == 1, "R3 busy after write", r, 1);
        wait_idle(100, cyc);
        check(cyc < 100, "R3 busy clears", 32'(cyc), 0);
        bus_read(8'h04, r); check(r == 32'h20, "R2 trig readback", r, 32'h20);
        check(log_n == 1 && chan_log[0] == 5, "R2 start chan", 32'(chan_log[0]), 5);
        bus_read(data_addr(5)[7:0], r); check(r == exp_word(5), "R4 data5", r, exp_word(5));

        // R5 falling trigger clears ready
        bus_write(8'h04, 32'h0000);
        bus_read(data_addr(5)[7:0], r);
        check(r[12] == 1'b0, "R5 ready cleared", r, {20'b0, exp_val[5]});

        // R9 writes ignored, unmapped reads zero
        bus_write(8'h04, 32'h0020);
        wait_idle(100, cyc);
        bus_write(data_addr(5)[7:0], 32'hFFFF_FFFF);
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_read(data_addr(5)[7:0], r); check(r == exp_word(5), "R9 data write", r, exp_word(5));
        bus_read(8'h10, r); check(r == 0, "R9 status write", r, 0);
        bus_read(8'h00, r); check(r == 0, "R9 unmapped 00", r, 0);
        bus_read(8'h08, r); check(r == 0, "R9 unmapped 08", r, 0);
        bus_read(8'h60, r); check(r == 0, "R9 unmapped 60", r, 0);
        bus_read(8'h16, r); check(r == 0, "R9 unaligned", r, 0);

        // R6 several rises in one write
        bus_write(8'h04, 32'h0000);
        base = log_n;
        bus_write(8'h04, 32'h8421);
        wait_idle(200, cyc);
        check(log_n - base == 4, "R3 busy until last", 32'(log_n - base), 4);
        check(chan_log[base] == 0 && chan_log[base+1] == 5 &&
              chan_log[base+2] == 10 && chan_log[base+3] == 15,
              "R6 order", 32'(chan_log[base+1]), 5);
        for (int c = 0; c < NCH; c += 5) begin
            bus_read(data_addr(c)[7:0], r); check(r == exp_word(c), "R4 multi", r, exp_word(c));
        end

        // R8 converter silent
        bus_write(8'h04, 32'h0000);
        mute = 1;
        bus_write(8'h04, 32'h0008);
        wait_idle(TMO + 20, cyc);
        check(cyc >= TMO && cyc <= TMO + 6, "R8 timeout window", 32'(cyc), TMO + 2);
        bus_read(data_addr(3)[7:0], r); check(r[12] == 1'b0, "R8 ready stays 0", r, 0);
        mute = 0;

        // R7 falling write while power off leaves ready
        bus_write(8'h04, 32'h0000);
        bus_write(8'h04, 32'h0004);
        wait_idle(100, cyc);
        bus_write(8'h94, 32'h0000);
        bus_write(8'h04, 32'h0000);
        bus_read(8'h04, r); check(r == 32'h4, "R7 trig kept", r, 32'h4);
        bus_read(data_addr(2)[7:0], r); check(r == exp_word(2), "R7 ready kept", r, exp_word(2));
        bus_write(8'h94, 32'h4000);

        // random masks: clear, set, poll
        for (int it = 0; it < 30; it++) begin
            automatic logic [15:0] m = 16'($urandom);
            automatic int k = 0;
            bus_write(8'h04, 32'h0000);
            for (int c = 0; c < NCH; c++) begin
                bus_read(data_addr(c)[7:0], r);
                check(r[12] == 1'b0, "R5 random clear", r, 0);
            end
            base = log_n;
            bus_write(8'h04, {16'b0, m});
            wait_idle(400, cyc);
            check(log_n - base == $countones(m), "R6 random count",
                  32'(log_n - base), 32'($countones(m)));
            for (int c = 0; c < NCH; c++) begin
                if (m[c]) begin
                    check(chan_log[(base + k) % 256] == c, "R6 random order",
                          32'(chan_log[(base + k) % 256]), 32'(c));
                    k++;
                    bus_read(data_addr(c)[7:0], r);
                    check(r == exp_word(c), "R4 random data", r, exp_word(c));
                end
            end
        end

        finish_up();
    end
endmodule